// File: doc/BRIEF.md
# CAN Data-Phase Bit Timing Generator

This block turns the module clock into time quanta and steps every bit through three segments. Each bit opens with a one-quantum synchronization segment. A first phase segment follows, covering propagation plus phase 1, and lasts `cfg_seg1 + 1` quanta. A second phase segment then lasts `cfg_seg2 + 1` quanta. A whole bit is therefore `cfg_seg1 + cfg_seg2 + 3` quanta long, and one quantum is `cfg_presc + 1` clocks. In every bit the block raises a one-clock sample strobe at the close of the first phase segment and a one-clock bit-end strobe at the close of the bit. No processing time separates the sample point from the next segment, so logic that shifts out the next bit can act on the first clock after the sample strobe.

Timing fields are loaded only while the block is halted and configuration is unlocked. A write that would make an illegal bit length is refused. While `init_hold` is high the sequencer sits in its idle state. When `init_hold` drops, bits start at once from a synchronization segment.

The sequencer has four states, shown on `seg_state`: IDLE (0), SYNC (1), PHASE1 (2) and PHASE2 (3). Its transitions are:
- START: IDLE to SYNC when `init_hold` is low.
- SYNC_DONE: SYNC to PHASE1 on a quantum tick.
- SAMPLE: PHASE1 to PHASE2 on the tick that ends its last quantum.
- BIT_END: PHASE2 to SYNC on the tick that ends its last quantum.
- HALT: any state to IDLE while `init_hold` is high.

Top module: `can_dbit_timer`

## Requirements
- R1: After reset the timing fields are prescaler 0, first segment 10 and second segment 3, giving a 16-quantum bit. `seg_state` is IDLE (0) and `tq_tick`, `sample_stb` and `bit_end_stb` are low.
- R2: While `init_hold` is high, `seg_state` stays IDLE (0) and all three strobes stay low. On the first clock after the edge that samples `init_hold` low, `seg_state` is SYNC (1).
- R3: While running, `tq_tick` is high for exactly one clock in every `cfg_presc + 1` clocks, namely the last clock of each quantum.
- R4: Each bit is SYNC (code 1) for 1 quantum, then PHASE1 (code 2) for first-segment + 1 quanta, then PHASE2 (code 3) for second-segment + 1 quanta. The next bit then starts in SYNC with no gap.
- R5: `sample_stb` is high for exactly the last clock of the final PHASE1 quantum. The next clock is already in PHASE2.
- R6: `bit_end_stb` is high for exactly the last clock of the final PHASE2 quantum. The next clock is in SYNC.
- R7: All three timing fields are captured on a clock edge only when `cfg_unlock` and `init_hold` are both high. On every other edge, including edges while bits are running, the old values are kept.
- R8: A write whose bit length (first + second + 3) falls outside 4 to 25 quanta is refused as a whole, and all three old fields are kept. Both limits, 4 and 25, are accepted.
- R9: Every prescaler field value from 0 to 1023 works, giving quanta of 1 to 1024 clocks.
- R10: If `init_hold` rises in the middle of a bit, `seg_state` is IDLE on the next clock and all strobes stay low. The next release starts a fresh bit at SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_unlock | input | 1 | Configuration change enable |
| init_hold | input | 1 | Initialization: halts timing and, with cfg_unlock, opens the fields for writes |
| cfg_presc | input | 10 | Prescaler field; quantum = value + 1 clocks |
| cfg_seg1 | input | 5 | First segment field (propagation + phase 1), in quanta minus one |
| cfg_seg2 | input | 4 | Second segment field (phase 2), in quanta minus one |
| tq_tick | output | 1 | High in the last clock of each time quantum |
| seg_state | output | 2 | Current segment: 0 idle, 1 sync, 2 phase 1, 3 phase 2 |
| sample_stb | output | 1 | Sample-point strobe |
| bit_end_stb | output | 1 | End-of-bit strobe |

## Verification
The bench runs the shortest legal bit (4 quanta) with the sample point placed both right after sync and one quantum later. It also runs the longest legal bit (25 quanta) and the largest prescaler value. An off-by-one in a segment count or in the quantum divider would move the strobes by a quantum or a clock, and every cycle is compared with a position computed from the fields. Writes made while locked, writes made while bits are running, and writes of lengths 3 and 26 are each followed by a run that must keep the old timing. A design that leaks any of these writes would show a different bit length. Raising `init_hold` mid-bit must give IDLE on the next clock and a clean restart at SYNC. A design that let the halt wait for the end of the bit, or kept a stale quantum count, would fail there.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_IDLE   = 2'd0,
        SEG_SYNC   = 2'd1,
        SEG_PHASE1 = 2'd2,
        SEG_PHASE2 = 2'd3
    } seg_e;

    localparam int unsigned RST_PRESC = 0;
    localparam int unsigned RST_SEG1  = 10;
    localparam int unsigned RST_SEG2  = 3;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter int unsigned PRESC_W    = 10,
    parameter int unsigned SEG1_W     = 5,
    parameter int unsigned SEG2_W     = 4,
    parameter int unsigned MIN_BIT_TQ = 4,
    parameter int unsigned MAX_BIT_TQ = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_unlock,
    input  logic               init_hold,
    input  logic [PRESC_W-1:0] wr_presc,
    input  logic [SEG1_W-1:0]  wr_seg1,
    input  logic [SEG2_W-1:0]  wr_seg2,
    output logic [PRESC_W-1:0] presc,
    output logic [SEG1_W-1:0]  seg1,
    output logic [SEG2_W-1:0]  seg2
);

    localparam int unsigned WIDE_W = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
    localparam int unsigned SUM_W  = WIDE_W + 2;

    logic [SUM_W-1:0] wr_total;
    logic [SUM_W-1:0] held_total;
    logic             wr_legal;
    logic             load;

    always_comb begin
        wr_total   = SUM_W'(wr_seg1) + SUM_W'(wr_seg2) + SUM_W'(3);
        held_total = SUM_W'(seg1) + SUM_W'(seg2) + SUM_W'(3);
        wr_legal   = (wr_total >= SUM_W'(MIN_BIT_TQ)) && (wr_total <= SUM_W'(MAX_BIT_TQ));
        load       = cfg_unlock && init_hold && wr_legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= PRESC_W'(RST_PRESC);
            seg1  <= SEG1_W'(RST_SEG1);
            seg2  <= SEG2_W'(RST_SEG2);
        end else if (load) begin
            presc <= wr_presc;
            seg1  <= wr_seg1;
            seg2  <= wr_seg2;
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_unlock && init_hold) |=> ($stable(presc) && $stable(seg1) && $stable(seg2)));

    // R8
    cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_total >= SUM_W'(MIN_BIT_TQ)) && (held_total <= SUM_W'(MAX_BIT_TQ)));

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int unsigned PRESC_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tq_tick
);

    logic [PRESC_W-1:0] pcnt;

    always_comb begin
        tq_tick = run && (pcnt == presc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || tq_tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PRESC_W'(1);
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && (presc != '0)) |=> !tq_tick);

    // R9
    pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt <= presc));

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int unsigned SEG1_W = 5,
    parameter int unsigned SEG2_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_hold,
    input  logic              tq_tick,
    input  logic [SEG1_W-1:0] seg1,
    input  logic [SEG2_W-1:0] seg2,
    output seg_e              state,
    output logic              run,
    output logic              sample_stb,
    output logic              bit_end_stb
);

    localparam int unsigned QW = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;

    seg_e          nxt_state;
    logic [QW-1:0] qcnt;
    logic [QW-1:0] nxt_qcnt;
    logic          last1;
    logic          last2;

    always_comb begin
        last1 = (qcnt == QW'(seg1));
        last2 = (qcnt == QW'(seg2));
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_qcnt  = qcnt;
        if (init_hold) begin
            nxt_state = SEG_IDLE;                       // HALT
            nxt_qcnt  = '0;
        end else begin
            unique case (state)
                SEG_IDLE: begin
                    nxt_state = SEG_SYNC;               // START
                    nxt_qcnt  = '0;
                end
                SEG_SYNC: begin
                    if (tq_tick) begin
                        nxt_state = SEG_PHASE1;         // SYNC_DONE
                        nxt_qcnt  = '0;
                    end
                end
                SEG_PHASE1: begin
                    if (tq_tick) begin
                        if (last1) begin
                            nxt_state = SEG_PHASE2;     // SAMPLE
                            nxt_qcnt  = '0;
                        end else begin
                            nxt_qcnt = qcnt + QW'(1);
                        end
                    end
                end
                SEG_PHASE2: begin
                    if (tq_tick) begin
                        if (last2) begin
                            nxt_state = SEG_SYNC;       // BIT_END
                            nxt_qcnt  = '0;
                        end else begin
                            nxt_qcnt = qcnt + QW'(1);
                        end
                    end
                end
                default: begin
                    nxt_state = SEG_IDLE;
                    nxt_qcnt  = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEG_IDLE;
            qcnt  <= '0;
        end else begin
            state <= nxt_state;
            qcnt  <= nxt_qcnt;
        end
    end

    // Outputs
    always_comb begin
        run         = (state != SEG_IDLE);
        sample_stb  = (state == SEG_PHASE1) && tq_tick && last1;
        bit_end_stb = (state == SEG_PHASE2) && tq_tick && last2;
    end

    // R4
    sync_to_phase1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_SYNC && tq_tick && !init_hold) |=> (state == SEG_PHASE1));

    // R4
    qcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_PHASE1) |-> (qcnt <= QW'(seg1)));

    // R5
    sample_to_phase2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (state == SEG_PHASE2 || state == SEG_IDLE));

    // R6
    end_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_stb |=> (state == SEG_SYNC || state == SEG_IDLE));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, bit_end_stb}));

    // R10
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_hold |=> (state == SEG_IDLE));

endmodule

// File: rtl/can_dbit_timer.sv
module can_dbit_timer
    import can_bt_pkg::*;
#(
    parameter int unsigned PRESC_W    = 10,
    parameter int unsigned SEG1_W     = 5,
    parameter int unsigned SEG2_W     = 4,
    parameter int unsigned MIN_BIT_TQ = 4,
    parameter int unsigned MAX_BIT_TQ = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_unlock,
    input  logic               init_hold,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [SEG1_W-1:0]  cfg_seg1,
    input  logic [SEG2_W-1:0]  cfg_seg2,
    output logic               tq_tick,
    output logic [1:0]         seg_state,
    output logic               sample_stb,
    output logic               bit_end_stb
);

    logic [PRESC_W-1:0] presc;
    logic [SEG1_W-1:0]  seg1;
    logic [SEG2_W-1:0]  seg2;
    logic               run;
    seg_e               state;

    can_bt_cfg #(
        .PRESC_W   (PRESC_W),
        .SEG1_W    (SEG1_W),
        .SEG2_W    (SEG2_W),
        .MIN_BIT_TQ(MIN_BIT_TQ),
        .MAX_BIT_TQ(MAX_BIT_TQ)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_unlock(cfg_unlock),
        .init_hold (init_hold),
        .wr_presc  (cfg_presc),
        .wr_seg1   (cfg_seg1),
        .wr_seg2   (cfg_seg2),
        .presc     (presc),
        .seg1      (seg1),
        .seg2      (seg2)
    );

    can_bt_prescaler #(
        .PRESC_W(PRESC_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .presc  (presc),
        .tq_tick(tq_tick)
    );

    can_bt_seq #(
        .SEG1_W(SEG1_W),
        .SEG2_W(SEG2_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_hold  (init_hold),
        .tq_tick    (tq_tick),
        .seg1       (seg1),
        .seg2       (seg2),
        .state      (state),
        .run        (run),
        .sample_stb (sample_stb),
        .bit_end_stb(bit_end_stb)
    );

    always_comb begin
        seg_state = state;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_state == 2'd0) |-> !(tq_tick || sample_stb || bit_end_stb));

endmodule

// File: tb/can_dbit_timer_tb.sv
module can_dbit_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_unlock = 1'b0;
    logic       init_hold = 1'b1;
    logic [9:0] cfg_presc = '0;
    logic [4:0] cfg_seg1 = '0;
    logic [3:0] cfg_seg2 = '0;
    logic       tq_tick;
    logic [1:0] seg_state;
    logic       sample_stb;
    logic       bit_end_stb;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_dbit_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_unlock (cfg_unlock),
        .init_hold  (init_hold),
        .cfg_presc  (cfg_presc),
        .cfg_seg1   (cfg_seg1),
        .cfg_seg2   (cfg_seg2),
        .tq_tick    (tq_tick),
        .seg_state  (seg_state),
        .sample_stb (sample_stb),
        .bit_end_stb(bit_end_stb)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic write_cfg(input int p, input int s1, input int s2, input bit unl);
        @(negedge clk);
        init_hold  = 1'b1;
        cfg_unlock = unl;
        cfg_presc  = 10'(p);
        cfg_seg1   = 5'(s1);
        cfg_seg2   = 4'(s2);
        @(negedge clk);
        cfg_unlock = 1'b0;
    endtask

    // Releases init and compares every cycle against positions computed from the fields.
    task automatic run_bits(input int p, input int s1, input int s2, input int nbits,
                            input string tag, input bit poke);
        int qp, blen, pos, q, e_tick, e_seg, e_smp, e_end;
        int nerr[4];
        int fa[4];
        int fe[4];
        for (int i = 0; i < 4; i++) begin
            nerr[i] = 0; fa[i] = 0; fe[i] = 0;
        end
        qp   = p + 1;
        blen = qp * (s1 + s2 + 3);
        @(negedge clk);
        init_hold = 1'b0;
        for (int k = 0; k < blen * nbits; k++) begin
            @(negedge clk);
            pos    = k % blen;
            q      = pos / qp;
            e_tick = ((pos % qp) == qp - 1) ? 1 : 0;
            e_seg  = (q == 0) ? 1 : ((q <= s1 + 1) ? 2 : 3);
            e_smp  = (pos == qp * (s1 + 2) - 1) ? 1 : 0;
            e_end  = (pos == blen - 1) ? 1 : 0;
            if (int'(tq_tick) != e_tick) begin
                if (nerr[0] == 0) begin fa[0] = int'(tq_tick); fe[0] = e_tick; end
                nerr[0]++;
            end
            if (int'(seg_state) != e_seg) begin
                if (nerr[1] == 0) begin fa[1] = int'(seg_state); fe[1] = e_seg; end
                nerr[1]++;
            end
            if (int'(sample_stb) != e_smp) begin
                if (nerr[2] == 0) begin fa[2] = int'(sample_stb); fe[2] = e_smp; end
                nerr[2]++;
            end
            if (int'(bit_end_stb) != e_end) begin
                if (nerr[3] == 0) begin fa[3] = int'(bit_end_stb); fe[3] = e_end; end
                nerr[3]++;
            end
            if (poke && k == 2) begin
                cfg_unlock = 1'b1;
                cfg_presc  = 10'd5;
                cfg_seg1   = 5'd2;
                cfg_seg2   = 4'd2;
            end
        end
        cfg_unlock = 1'b0;
        init_hold  = 1'b1;
        check(nerr[0] == 0, {tag, " R3 quantum tick"}, fa[0], fe[0]);
        check(nerr[1] == 0, {tag, " R4 segment order"}, fa[1], fe[1]);
        check(nerr[2] == 0, {tag, " R5 sample strobe"}, fa[2], fe[2]);
        check(nerr[3] == 0, {tag, " R6 bit end strobe"}, fa[3], fe[3]);
    endtask

    task automatic test_reset();
        repeat (2) @(negedge clk);
        check(seg_state == 2'd0, "R1 reset segment", int'(seg_state), 0);
        check(!(tq_tick || sample_stb || bit_end_stb), "R1 reset strobes",
              int'({tq_tick, sample_stb, bit_end_stb}), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_init_hold();
        int bad = 0;
        init_hold = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (seg_state != 2'd0 || tq_tick || sample_stb || bit_end_stb) bad++;
        end
        check(bad == 0, "R2 idle while held", bad, 0);
    endtask

    task automatic test_default();
        run_bits(0, 10, 3, 2, "R1 default", 1'b0);
    endtask

    task automatic test_shapes();
        write_cfg(0, 1, 0, 1'b1);
        run_bits(0, 1, 0, 3, "R4 min bit late sample", 1'b0);
        write_cfg(1, 0, 1, 1'b1);
        run_bits(1, 0, 1, 2, "R5 min bit early sample", 1'b0);
        write_cfg(2, 15, 7, 1'b1);
        run_bits(2, 15, 7, 2, "R6 max bit", 1'b0);
        write_cfg(1023, 1, 0, 1'b1);
        run_bits(1023, 1, 0, 2, "R9 max prescaler", 1'b0);
    endtask

    task automatic test_lock();
        write_cfg(1, 4, 2, 1'b1);
        write_cfg(6, 9, 9, 1'b0);
        run_bits(1, 4, 2, 2, "R7 locked write", 1'b1);
        run_bits(1, 4, 2, 1, "R7 write while running", 1'b0);
    endtask

    task automatic test_illegal();
        write_cfg(0, 0, 0, 1'b1);
        run_bits(1, 4, 2, 1, "R8 length 3 refused", 1'b0);
        write_cfg(3, 20, 3, 1'b1);
        run_bits(1, 4, 2, 1, "R8 length 26 refused", 1'b0);
        write_cfg(0, 22, 0, 1'b1);
        run_bits(0, 22, 0, 1, "R8 length 25 accepted", 1'b0);
    endtask

    task automatic test_halt();
        write_cfg(0, 10, 3, 1'b1);
        @(negedge clk);
        init_hold = 1'b0;
        repeat (6) @(negedge clk);
        init_hold = 1'b1;
        @(negedge clk);
        check(seg_state == 2'd0, "R10 idle after halt", int'(seg_state), 0);
        check(!(sample_stb || bit_end_stb), "R10 strobes after halt",
              int'({sample_stb, bit_end_stb}), 0);
        @(negedge clk);
        check(!tq_tick, "R10 tick stopped", int'(tq_tick), 0);
        run_bits(0, 10, 3, 1, "R10 restart", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_init_hold();
        test_default();
        test_shapes();
        test_lock();
        test_illegal();
        test_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule